// File: doc/BRIEF.md
# Receive Chunk Footer Generator

This block produces the device-to-host half of each data chunk on a serial MAC-PHY link. When a host data header has been parsed, the block emits a fixed-length chunk one byte per clock. The chunk carries 64 payload bytes read from an external receive frame store, then a 32-bit footer sent most significant byte first. The footer tells the host whether the payload holds frame data and where a frame starts or ends within it. It also reports how many further receive chunks are waiting, how many transmit chunks the device can still absorb, whether a status event or a bad header was seen, and whether the configuration has been synchronized.

The block also drives an active-low interrupt. The interrupt is raised when receive data, transmit credits or an unmasked status event appears where the last footer reported none. It is removed when the first data header of the next transaction arrives. The frame memory sits outside the block and is addressed through a payload index. A one-cycle pop pulse tells the store that a chunk of frame data has been delivered.

Top module: `rx_footer_gen`

## Requirements
- R1: A `chunk_start` pulse while idle produces exactly 68 consecutive cycles with `miso_valid` high: 64 payload bytes in index order, then the four footer bytes from bits 31:24 down to 7:0. A `chunk_start` during a chunk is ignored, and `miso_valid` is low whenever no chunk is in progress.
- R2: When the chunk carries data, payload byte k equals the frame store byte returned for `pay_idx` = k. When the chunk carries no data, every payload byte is 0x00.
- R3: Footer bit 0 makes the number of ones across all 32 footer bits odd.
- R4: Footer bit 31 is set when any status bit is set and its mask bit is clear. Bit 30 repeats `hdr_bad` as captured with the header. Bit 29 repeats `cfg_sync`.
- R5: Footer bits 28:24 equal `rx_ready` minus one when the chunk carries data, and equal `rx_ready` otherwise, sampled as the last payload byte is sent.
- R6: The chunk carries data (footer bit 21) only when `rx_ready` is nonzero and `hdr_norx` is clear at the header. Bit 20 is the start flag and bits 19:16 the start word. Bit 14 is the end flag and bits 13:8 the last byte offset. Each offset is 0 when its flag is 0, and all of them are 0 when bit 21 is 0.
- R7: Footer bit 15 (drop request) is 1 only when `rx_fd` was requested and bit 14 is 1.
- R8: Footer bits 5:1 equal `tx_credits` sampled with the last payload byte. Bits 23:22 and 7:6 are always 0.
- R9: `chunk_pop` is high for exactly one cycle per chunk that carries data, and never for a chunk without data.
- R10: Outside a chunk, `irq_n` goes low when receive chunks, transmit credits or an unmasked status event are present and the corresponding footer field was zero in the last footer sent. Reset counts as a footer with all three fields zero.
- R11: A `chunk_start` with `hdr_first` set while idle drives `irq_n` high on the next cycle, and `irq_n` stays high for the rest of that chunk.
- R12: After reset, `irq_n` is high and `miso_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chunk_start | input | 1 | Parsed data header present, begin a chunk |
| hdr_first | input | 1 | Header is the first of a transaction |
| hdr_norx | input | 1 | Host refuses receive data for this chunk |
| hdr_bad | input | 1 | A host header failed its parity check |
| rx_ready | input | 5 | Receive chunks buffered, including the current one |
| rx_sv | input | 1 | Frame start lies in the next chunk |
| rx_swo | input | 4 | Word offset of that frame start |
| rx_ev | input | 1 | Frame end lies in the next chunk |
| rx_ebo | input | 6 | Byte offset of that frame end |
| rx_fd | input | 1 | Frame should be dropped by the host |
| pay_idx | output | 6 | Payload byte index into the frame store |
| pay_byte | input | 8 | Frame store byte at `pay_idx` |
| chunk_pop | output | 1 | Current chunk of frame data consumed |
| tx_credits | input | 5 | Free transmit chunk buffers |
| status_bits | input | 8 | Raw status events |
| status_mask | input | 8 | Per-bit status mask, 1 hides the bit |
| cfg_sync | input | 1 | Configuration synchronized |
| miso_byte | output | 8 | Outgoing byte |
| miso_valid | output | 1 | `miso_byte` holds a chunk byte |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Taking the `chunk_start` edge as edge 0, byte k of the chunk is registered at edge k+1. The footer bytes therefore land at edges 65 to 68, and `miso_valid` falls at edge 69. The bench drives on falling edges and reads one byte at every falling edge after the start edge. It samples `chunk_pop` at the falling edge after edge 63, where the counter sits on the last payload index. It looks at `irq_n` one falling edge after a header for the clear, and a few cycles after an input change for a raise.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int PAY_BYTES   = 64;
  localparam int FTR_BYTES   = 4;
  localparam int CHUNK_BYTES = PAY_BYTES + FTR_BYTES;
  localparam int CNT_W       = $clog2(CHUNK_BYTES);
  localparam int IDX_W       = $clog2(PAY_BYTES);
  localparam int SWO_W       = $clog2(PAY_BYTES / 4);
  localparam int RCA_W       = 5;
  localparam int TXC_W       = 5;

  typedef struct packed {
    logic             sv;
    logic [SWO_W-1:0] swo;
    logic             ev;
    logic [IDX_W-1:0] ebo;
    logic             fd;
  } frame_desc_t;
endpackage

// File: rtl/rxf_seq.sv
module rxf_seq
  import rxf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_pay_o
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CHUNK_BYTES - 1);
  localparam logic [CNT_W-1:0] LAST_PAY = CNT_W'(PAY_BYTES - 1);

  assign accept_o   = start_i && !busy_o;
  assign last_pay_o = busy_o && (cnt_o == LAST_PAY);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      cnt_o  <= '0;
    end else if (accept_o) begin
      busy_o <= 1'b1;
      cnt_o  <= '0;
    end else if (busy_o) begin
      if (cnt_o == LAST_CNT) busy_o <= 1'b0;
      else                   cnt_o  <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/rxf_footer.sv
module rxf_footer
  import rxf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             accept_i,
  input  logic             norx_i,
  input  logic             hdrb_i,
  input  frame_desc_t      desc_i,
  input  logic [RCA_W-1:0] ready_i,
  input  logic             last_pay_i,
  input  logic [TXC_W-1:0] credits_i,
  input  logic             exst_i,
  input  logic             sync_i,
  output logic             dv_o,
  output logic [31:0]      footer_o
);
  frame_desc_t desc_q;
  logic        hdrb_q;
  logic        dv_next;
  frame_desc_t desc_clean;
  logic [RCA_W-1:0] rca;
  logic [31:1] body;

  assign dv_next = (ready_i != '0) && !norx_i;

  always_comb begin
    desc_clean     = '0;
    if (dv_next) begin
      desc_clean.sv  = desc_i.sv;
      desc_clean.swo = desc_i.sv ? desc_i.swo : '0;
      desc_clean.ev  = desc_i.ev;
      desc_clean.ebo = desc_i.ev ? desc_i.ebo : '0;
      desc_clean.fd  = desc_i.ev && desc_i.fd;
    end
  end

  assign rca  = ready_i - RCA_W'(dv_o);
  assign body = {exst_i, hdrb_q, sync_i, rca, 2'b00,
                 dv_o, desc_q.sv, desc_q.swo, desc_q.fd, desc_q.ev, desc_q.ebo,
                 2'b00, credits_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      dv_o     <= 1'b0;
      desc_q   <= '0;
      hdrb_q   <= 1'b0;
      footer_o <= '0;
    end else begin
      if (accept_i) begin
        dv_o   <= dv_next;
        desc_q <= desc_clean;
        hdrb_q <= hdrb_i;
      end
      if (last_pay_i) footer_o <= {body, ~(^body)};
    end
  end
endmodule

// File: rtl/rxf_irq.sv
module rxf_irq (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic hold_i,
  input  logic upd_i,
  input  logic rx_any_i,
  input  logic tx_any_i,
  input  logic ev_any_i,
  input  logic ftr_rca_zero_i,
  input  logic ftr_txc_zero_i,
  input  logic ftr_exst_zero_i,
  output logic irq_n_o
);
  logic prev_rz, prev_tz, prev_ez;
  logic raise;

  assign raise = !hold_i && ((prev_rz && rx_any_i) ||
                             (prev_tz && tx_any_i) ||
                             (prev_ez && ev_any_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_rz <= 1'b1;
      prev_tz <= 1'b1;
      prev_ez <= 1'b1;
      irq_n_o <= 1'b1;
    end else begin
      if (upd_i) begin
        prev_rz <= ftr_rca_zero_i;
        prev_tz <= ftr_txc_zero_i;
        prev_ez <= ftr_exst_zero_i;
      end
      if (clear_i)    irq_n_o <= 1'b1;
      else if (raise) irq_n_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_footer_gen.sv
module rx_footer_gen
  import rxf_pkg::*;
#(
  parameter int ST_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chunk_start,
  input  logic             hdr_first,
  input  logic             hdr_norx,
  input  logic             hdr_bad,
  input  logic [RCA_W-1:0] rx_ready,
  input  logic             rx_sv,
  input  logic [SWO_W-1:0] rx_swo,
  input  logic             rx_ev,
  input  logic [IDX_W-1:0] rx_ebo,
  input  logic             rx_fd,
  output logic [IDX_W-1:0] pay_idx,
  input  logic [7:0]       pay_byte,
  output logic             chunk_pop,
  input  logic [TXC_W-1:0] tx_credits,
  input  logic [ST_W-1:0]  status_bits,
  input  logic [ST_W-1:0]  status_mask,
  input  logic             cfg_sync,
  output logic [7:0]       miso_byte,
  output logic             miso_valid,
  output logic             irq_n
);
  localparam logic [CNT_W-1:0] FTR_FIRST = CNT_W'(PAY_BYTES);

  logic             accept, busy, last_pay, dv;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      footer;
  logic             exst_now;
  frame_desc_t      desc;

  assign exst_now = |(status_bits & ~status_mask);
  assign desc     = '{sv: rx_sv, swo: rx_swo, ev: rx_ev, ebo: rx_ebo, fd: rx_fd};

  rxf_seq seq_i (
    .clk(clk), .rst(rst), .start_i(chunk_start), .accept_o(accept),
    .busy_o(busy), .cnt_o(cnt), .last_pay_o(last_pay)
  );

  rxf_footer ftr_i (
    .clk(clk), .rst(rst), .accept_i(accept), .norx_i(hdr_norx),
    .hdrb_i(hdr_bad), .desc_i(desc), .ready_i(rx_ready),
    .last_pay_i(last_pay), .credits_i(tx_credits), .exst_i(exst_now),
    .sync_i(cfg_sync), .dv_o(dv), .footer_o(footer)
  );

  rxf_irq irq_i (
    .clk(clk), .rst(rst),
    .clear_i(accept && hdr_first),
    .hold_i(busy || chunk_start),
    .upd_i(busy && (cnt == FTR_FIRST)),
    .rx_any_i(rx_ready != '0),
    .tx_any_i(tx_credits != '0),
    .ev_any_i(exst_now),
    .ftr_rca_zero_i(footer[28:24] == 5'd0),
    .ftr_txc_zero_i(footer[5:1] == 5'd0),
    .ftr_exst_zero_i(!footer[31]),
    .irq_n_o(irq_n)
  );

  assign pay_idx   = cnt[IDX_W-1:0];
  assign chunk_pop = last_pay && dv;

  always_ff @(posedge clk) begin
    if (rst) begin
      miso_valid <= 1'b0;
      miso_byte  <= '0;
    end else begin
      miso_valid <= busy;
      if (busy) begin
        if (cnt < FTR_FIRST) miso_byte <= dv ? pay_byte : 8'h00;
        else                 miso_byte <= footer[8*(3 - int'(cnt[1:0])) +: 8];
      end else begin
        miso_byte <= 8'h00;
      end
    end
  end
endmodule

// File: rtl/rx_footer_gen_chk.sv
module rx_footer_gen_chk (
  input logic        clk,
  input logic        rst,
  input logic        chunk_start,
  input logic        hdr_first,
  input logic        busy,
  input logic [6:0]  cnt,
  input logic [31:0] footer,
  input logic        miso_valid,
  input logic        chunk_pop,
  input logic        irq_n
);
  logic ftr_phase;
  assign ftr_phase = busy && (cnt >= 7'd64);

  assert_start_R1: assert property (@(posedge clk) disable iff (rst)
    (chunk_start && !busy) |=> (busy && cnt == 7'd0));
  assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !miso_valid);
  assert_parity_R3: assert property (@(posedge clk) disable iff (rst)
    ftr_phase |-> (^footer == 1'b1));
  assert_swo_R6: assert property (@(posedge clk) disable iff (rst)
    (ftr_phase && !footer[20]) |-> (footer[19:16] == 4'd0));
  assert_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (ftr_phase && footer[15]) |-> footer[14]);
  assert_pop_R9: assert property (@(posedge clk) disable iff (rst)
    chunk_pop |=> !chunk_pop);
  assert_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (chunk_start && hdr_first && !busy) |=> irq_n);
endmodule

bind rx_footer_gen rx_footer_gen_chk chk_i (
  .clk(clk), .rst(rst), .chunk_start(chunk_start), .hdr_first(hdr_first),
  .busy(busy), .cnt(cnt), .footer(footer), .miso_valid(miso_valid),
  .chunk_pop(chunk_pop), .irq_n(irq_n)
);

// File: tb/rx_footer_gen_tb_top.sv
`timescale 1ns/1ps
module rx_footer_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       chunk_start = 0, hdr_first = 0, hdr_norx = 0, hdr_bad = 0;
  logic [4:0] rx_ready = 0;
  logic       rx_sv = 0, rx_ev = 0, rx_fd = 0;
  logic [3:0] rx_swo = 0;
  logic [5:0] rx_ebo = 0;
  logic [5:0] pay_idx;
  logic [7:0] pay_byte;
  logic       chunk_pop;
  logic [4:0] tx_credits = 0;
  logic [7:0] status_bits = 0, status_mask = 0;
  logic       cfg_sync = 0;
  logic [7:0] miso_byte;
  logic       miso_valid, irq_n;
  logic [7:0] seed = 8'h5A;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  assign pay_byte = {pay_idx, 2'b01} ^ seed;

  rx_footer_gen dut_i (
    .clk(clk), .rst(rst), .chunk_start(chunk_start), .hdr_first(hdr_first),
    .hdr_norx(hdr_norx), .hdr_bad(hdr_bad), .rx_ready(rx_ready),
    .rx_sv(rx_sv), .rx_swo(rx_swo), .rx_ev(rx_ev), .rx_ebo(rx_ebo),
    .rx_fd(rx_fd), .pay_idx(pay_idx), .pay_byte(pay_byte),
    .chunk_pop(chunk_pop), .tx_credits(tx_credits),
    .status_bits(status_bits), .status_mask(status_mask),
    .cfg_sync(cfg_sync), .miso_byte(miso_byte), .miso_valid(miso_valid),
    .irq_n(irq_n)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_footer(input bit dv, input bit norx_hb);
    logic [31:1] b;
    logic        sv, ev, fd;
    logic [3:0]  swo;
    logic [5:0]  ebo;
    sv  = dv && rx_sv;
    swo = sv ? rx_swo : 4'd0;
    ev  = dv && rx_ev;
    ebo = ev ? rx_ebo : 6'd0;
    fd  = ev && rx_fd;
    b = {|(status_bits & ~status_mask), norx_hb, cfg_sync,
         5'(rx_ready - 5'(dv)), 2'b00, dv, sv, swo, fd, ev, ebo, 2'b00, tx_credits};
    return {b, ~(^b)};
  endfunction

  task automatic run_chunk(input bit norx, input bit first, input bit hb, input bit poke, input string tag);
    bit          dv;
    logic [31:0] ftr, expf;
    int          bad_pay, pops, bad_valid;
    dv = (rx_ready != 0) && !norx;
    expf = exp_footer(dv, hb);
    @(negedge clk);
    chunk_start = 1; hdr_first = first; hdr_norx = norx; hdr_bad = hb;
    @(negedge clk);
    chunk_start = 0; hdr_first = 0; hdr_norx = 0; hdr_bad = 0;
    if (first) chk(irq_n == 1'b1, {"R11 irq cleared by first header ", tag}, 32'(irq_n), 32'd1);
    bad_pay = 0; pops = 0; bad_valid = 0; ftr = '0;
    for (int k = 0; k < 68; k++) begin
      @(negedge clk);
      chunk_start = (poke && k == 10);
      if (chunk_pop) pops++;
      if (!miso_valid) bad_valid++;
      if (k < 64) begin
        if (miso_byte !== (dv ? ({6'(k), 2'b01} ^ seed) : 8'h00)) bad_pay++;
      end else begin
        ftr = {ftr[23:0], miso_byte};
      end
      if (k > 4 && k < 60 && irq_n !== 1'b1 && first)
        bad_valid += 1000;
    end
    chunk_start = 0;
    chk(bad_valid == 0, {"R1/R11 valid run, irq held ", tag}, 32'(bad_valid), 32'd0);
    chk(bad_pay == 0, {"R2 payload bytes ", tag}, 32'(bad_pay), 32'd0);
    chk(ftr === expf, {"R3 R4 R5 R6 R7 R8 footer ", tag}, ftr, expf);
    chk(pops == int'(dv), {"R9 pop count ", tag}, 32'(pops), 32'(dv));
    @(negedge clk);
    chk(miso_valid == 1'b0, {"R1 valid low after chunk ", tag}, 32'(miso_valid), 32'd0);
  endtask

  task automatic t_reset();
    chk(irq_n == 1'b1, "R12 irq_n after reset", 32'(irq_n), 32'd1);
    chk(miso_valid == 1'b0, "R12 miso_valid after reset", 32'(miso_valid), 32'd0);
  endtask

  task automatic t_rx_irq_and_data();
    rx_ready = 5'd2;
    repeat (3) @(negedge clk);
    chk(irq_n == 1'b0, "R10 irq on receive data", 32'(irq_n), 32'd0);
    rx_sv = 1; rx_swo = 4'd3; rx_ev = 1; rx_ebo = 6'd37; rx_fd = 1; cfg_sync = 1;
    run_chunk(0, 1, 0, 0, "data");
    repeat (3) @(negedge clk);
    chk(irq_n == 1'b1, "R10 no irq without zero-to-nonzero", 32'(irq_n), 32'd1);
  endtask

  task automatic t_tx_irq_norx();
    tx_credits = 5'd5;
    repeat (3) @(negedge clk);
    chk(irq_n == 1'b0, "R10 irq on transmit credits", 32'(irq_n), 32'd0);
    seed = 8'hC3;
    run_chunk(1, 1, 0, 0, "norx");
  endtask

  task automatic t_masked_end();
    rx_ready = 5'd1; rx_sv = 0; rx_swo = 4'd5; rx_ev = 1; rx_ebo = 6'd63; rx_fd = 1;
    status_bits = 8'h10; status_mask = 8'h10; cfg_sync = 0; tx_credits = 5'd31;
    run_chunk(0, 0, 1, 1, "end-masked-poke");
  endtask

  task automatic t_exst_irq_fd_noev();
    status_mask = 8'h00;
    repeat (3) @(negedge clk);
    chk(irq_n == 1'b0, "R10 irq on status event", 32'(irq_n), 32'd0);
    rx_ready = 5'd3; rx_sv = 1; rx_swo = 4'd15; rx_ev = 0; rx_fd = 1; tx_credits = 5'd0;
    run_chunk(0, 1, 0, 0, "fd-without-ev");
  endtask

  task automatic t_empty();
    rx_ready = 5'd0; status_bits = 8'h00;
    run_chunk(0, 0, 0, 0, "empty");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_rx_irq_and_data();
    t_tx_irq_norx();
    t_masked_end();
    t_exst_irq_fd_noev();
    t_empty();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule